// File: doc/BRIEF.md
# Two-Level Masked Interrupt Tree

This block collects interrupt events into one interrupt line through two levels of pending and mask registers. Two second-level groups, a 32-bit USB-core group and a 32-bit DMA group, each keep a pending register and a mask. The unmasked pending bits of each group fold into fixed summary bits of a 32-bit top-level pending register. The top level has its own mask. Its other bits are set and cleared either by software or directly by event inputs.

Software uses a single-cycle register port. A write takes effect at the clock edge, and a read returns data combinationally from the current address. Each pending register has three addresses. A plain read returns the pending value. A write-one-to-set address ORs the written data in, and a write-one-to-clear address clears the bits written as one.

The interrupt output is registered. Its polarity is programmable, and it is held low until the power-ready input is high.

Top module: `irq_tree`

## Requirements
- R1: After reset the top pending register reads 0, the top mask reads 0xFFFFFFFF, both group masks read 0xFFFFFFFF, the control word reads 0, and `irq_o` is low.
- R2: The address map is: 0 top pending, 1 top set, 2 top clear, 3 top mask, 4 USB pending, 5 USB set, 6 USB clear, 7 USB mask, 8 DMA pending, 9 DMA set, 10 DMA clear, 11 DMA mask, 12 control. A set write ORs `wdata` into the group's pending register, and a clear write removes the bits of `wdata` from it.
- R3: When a bit is set and cleared in the same cycle, from any mix of port writes and event inputs, it ends up set.
- R4: Top bit 9 reads 1 exactly when some bit in USB pending[15:0] is pending and unmasked.
- R5: Top bit 8 reads 1 exactly when some bit in USB pending[31:16] is pending and unmasked.
- R6: Top bit 24 reads 1 exactly when some DMA pending bit is pending and unmasked.
- R7: Top bits 8, 9 and 24 follow only their groups. Set and clear writes, and event inputs, on those positions have no effect.
- R8: A mask write changes the summary bits that reads return in the cycle right after the write.
- R9: Reads of a set address or a clear address return that group's pending value. Reads of addresses 13 to 15 return 0.
- R10: A one on `evt_set_i` sets that top bit at the next clock edge, and a one on `evt_clr_i` clears it. A one on `usb_evt_i` or `dma_evt_i` sets that bit of the group.
- R11: When control bit 17 is 1, `irq_o` is high one cycle after any unmasked top bit is pending while `ready_i` is high. When control bit 17 is 0, `irq_o` is high one cycle after no unmasked top bit is pending while `ready_i` is high.
- R12: `irq_o` is low in the cycle after any cycle in which `ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| evt_set_i | input | 32 | Per-bit direct set of top pending |
| evt_clr_i | input | 32 | Per-bit direct clear of top pending |
| usb_evt_i | input | 32 | Per-bit set of USB group pending |
| dma_evt_i | input | 32 | Per-bit set of DMA group pending |
| ready_i | input | 1 | Power-ready qualifier for the output |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: 32-bit groups, a 16/16 split of the USB group, and summary bits at 9, 8 and 24. At this size every single bit of both groups can be walked through set, summary and clear. The same applies to every top-level bit, including the three protected summary positions. The output test steps through all eight combinations of polarity, ready and pending. The tests also cover the set-over-clear conflict, a walking mask, and the unmapped addresses.

// File: rtl/irq_tree.sv
module irq_tree #(
  parameter int W       = 32,
  parameter int AW      = 4,
  parameter int TX_BIT  = 9,
  parameter int RX_BIT  = 8,
  parameter int DMA_BIT = 24,
  parameter int POL_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  evt_set_i,
  input  logic [W-1:0]  evt_clr_i,
  input  logic [W-1:0]  usb_evt_i,
  input  logic [W-1:0]  dma_evt_i,
  input  logic          ready_i,
  output logic          irq_o
);
  localparam int HALF = W / 2;
  localparam logic [AW-1:0] A_TOP = AW'(0), A_TSET = AW'(1), A_TCLR = AW'(2), A_TMSK = AW'(3);
  localparam logic [AW-1:0] A_USB = AW'(4), A_USET = AW'(5), A_UCLR = AW'(6), A_UMSK = AW'(7);
  localparam logic [AW-1:0] A_DMA = AW'(8), A_DSET = AW'(9), A_DCLR = AW'(10), A_DMSK = AW'(11);
  localparam logic [AW-1:0] A_CTL = AW'(12);
  localparam logic [W-1:0] SUM_MASK = (W'(1) << TX_BIT) | (W'(1) << RX_BIT) | (W'(1) << DMA_BIT);

  logic [W-1:0] top_q, top_msk_q, usb_q, usb_msk_q, dma_q, dma_msk_q, ctl_q;
  logic         irq_q;

  function automatic logic [W-1:0] wsel(input logic hit, input logic [W-1:0] d);
    return hit ? d : '0;
  endfunction

  logic [W-1:0] usb_nxt, dma_nxt, top_nxt, usb_pend, top_view;
  logic         tx_sum, rx_sum, dma_sum, any_pend;

  assign usb_nxt = (usb_q & ~wsel(wr_en && addr == A_UCLR, wdata))
                 | wsel(wr_en && addr == A_USET, wdata) | usb_evt_i;
  assign dma_nxt = (dma_q & ~wsel(wr_en && addr == A_DCLR, wdata))
                 | wsel(wr_en && addr == A_DSET, wdata) | dma_evt_i;
  assign top_nxt = ((top_q & ~(wsel(wr_en && addr == A_TCLR, wdata) | evt_clr_i))
                 | wsel(wr_en && addr == A_TSET, wdata) | evt_set_i) & ~SUM_MASK;

  assign usb_pend = usb_q & ~usb_msk_q;
  assign tx_sum   = |usb_pend[HALF-1:0];
  assign rx_sum   = |usb_pend[W-1:HALF];
  assign dma_sum  = |(dma_q & ~dma_msk_q);
  assign top_view = top_q | (W'(tx_sum) << TX_BIT) | (W'(rx_sum) << RX_BIT) | (W'(dma_sum) << DMA_BIT);
  assign any_pend = |(top_view & ~top_msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q     <= '0;
      usb_q     <= '0;
      dma_q     <= '0;
      top_msk_q <= '1;
      usb_msk_q <= '1;
      dma_msk_q <= '1;
      ctl_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      top_q <= top_nxt;
      usb_q <= usb_nxt;
      dma_q <= dma_nxt;
      if (wr_en && addr == A_TMSK) top_msk_q <= wdata;
      if (wr_en && addr == A_UMSK) usb_msk_q <= wdata;
      if (wr_en && addr == A_DMSK) dma_msk_q <= wdata;
      if (wr_en && addr == A_CTL)  ctl_q     <= wdata;
      irq_q <= ready_i & (ctl_q[POL_BIT] ? any_pend : ~any_pend);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    case (addr)
      A_TOP, A_TSET, A_TCLR: rdata = top_view;
      A_TMSK:                rdata = top_msk_q;
      A_USB, A_USET, A_UCLR: rdata = usb_q;
      A_UMSK:                rdata = usb_msk_q;
      A_DMA, A_DSET, A_DCLR: rdata = dma_q;
      A_DMSK:                rdata = dma_msk_q;
      A_CTL:                 rdata = ctl_q;
      default:               rdata = '0;
    endcase
  end

  // R12
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> !irq_o);

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TSET) |=> ((top_q & $past(wdata & ~SUM_MASK)) == $past(wdata & ~SUM_MASK)));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TCLR) |=> ((top_q & $past(wdata & ~evt_set_i)) == '0));

  // R10
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set_i & ~SUM_MASK) != '0) |=> ((top_q & $past(evt_set_i & ~SUM_MASK)) == $past(evt_set_i & ~SUM_MASK)));

  // R11
  pol_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[POL_BIT] && ready_i && ((top_view & ~top_msk_q) != '0)) |=> irq_o);

  // R7
  sum_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_q == '0 && dma_q == '0) |-> ((rdata & SUM_MASK) == '0 || addr > A_TCLR));
endmodule

// File: tb/irq_tree_tb_top.sv
module irq_tree_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0, ready_i = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, evt_set_i = 0, evt_clr_i = 0, usb_evt_i = 0, dma_evt_i = 0;
  logic [31:0] rdata;
  logic        irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] SUMS = 32'h0100_0300;

  irq_tree dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set_i(evt_set_i), .evt_clr_i(evt_clr_i), .usb_evt_i(usb_evt_i),
    .dma_evt_i(dma_evt_i), .ready_i(ready_i), .irq_o(irq_o));

  always #5 clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got %0d exp %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk_rd("R1", 0, 0);
    chk_rd("R1", 3, 32'hFFFF_FFFF);
    chk_rd("R1", 7, 32'hFFFF_FFFF);
    chk_rd("R1", 11, 32'hFFFF_FFFF);
    chk_rd("R1", 12, 0);
    chk("R1", {31'b0, irq_o}, 0);

    wr(7, 0);
    wr(11, 0);
    for (int i = 0; i < 32; i++) begin
      wr(5, 32'h1 << i);
      chk_rd("R2", 4, 32'h1 << i);
      chk_rd((i < 16) ? "R4" : "R5", 0, (i < 16) ? 32'h200 : 32'h100);
      wr(6, 32'h1 << i);
      chk_rd("R2", 4, 0);
      chk_rd("R4", 0, 0);
    end
    for (int i = 0; i < 32; i++) begin
      wr(9, 32'h1 << i);
      chk_rd("R9", 10, 32'h1 << i);
      chk_rd("R6", 0, 32'h0100_0000);
      wr(10, 32'h1 << i);
      chk_rd("R6", 0, 0);
    end

    // R8
    wr(5, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      wr(7, ~(32'h1 << i));
      chk_rd("R8", 0, (i < 16) ? 32'h200 : 32'h100);
    end
    wr(7, 32'hFFFF_FFFF);
    chk_rd("R8", 0, 0);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 0);

    // R7
    for (int i = 0; i < 32; i++) begin
      wr(1, 32'h1 << i);
      chk_rd("R7", 0, (32'h1 << i) & ~SUMS);
      chk_rd("R9", 1, (32'h1 << i) & ~SUMS);
      chk_rd("R9", 2, (32'h1 << i) & ~SUMS);
      wr(2, 32'h1 << i);
      chk_rd("R2", 0, 0);
    end

    // R3
    evt_clr_i = 32'hFFFF_FFFF;
    wr(1, 32'h0000_1000);
    evt_clr_i = 0;
    chk_rd("R3", 0, 32'h0000_1000);
    evt_set_i = 32'h0000_1000;
    wr(2, 32'h0000_1000);
    evt_set_i = 0;
    chk_rd("R3", 0, 32'h0000_1000);
    usb_evt_i = 32'h4;
    wr(6, 32'h4);
    usb_evt_i = 0;
    chk_rd("R3", 4, 32'h4);
    wr(6, 32'h4);
    wr(2, 32'hFFFF_FFFF);

    // R10
    @(negedge clk); evt_set_i = 32'h0001_0300;
    @(negedge clk); evt_set_i = 0;
    chk_rd("R10", 0, 32'h0001_0000);
    @(negedge clk); evt_clr_i = 32'h0001_0000;
    @(negedge clk); evt_clr_i = 0;
    chk_rd("R10", 0, 0);
    @(negedge clk); dma_evt_i = 32'h8000_0000;
    @(negedge clk); dma_evt_i = 0;
    chk_rd("R10", 8, 32'h8000_0000);
    chk_rd("R10", 0, 32'h0100_0000);
    wr(10, 32'hFFFF_FFFF);

    // R9
    chk_rd("R9", 13, 0);
    chk_rd("R9", 14, 0);
    chk_rd("R9", 15, 0);

    // R11 R12
    wr(3, ~32'h2000);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 2; r++)
        for (int q = 0; q < 2; q++) begin
          wr(12, p ? 32'h0002_0000 : 0);
          wr(q ? 1 : 2, 32'h2000);
          @(negedge clk); ready_i = r[0];
          @(negedge clk); @(negedge clk);
          chk(r ? "R11" : "R12", {31'b0, irq_o}, {31'b0, r[0] & (p ? q[0] : !q[0])});
        end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule